// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable total ratio of P·N + A. A digital model of a dual-modulus prescaler counts input cycles in groups of P or P+1. An 11-bit main counter counts prescaler groups up to N. A 7-bit swallow counter keeps the prescaler at P+1 for the first A groups of each period. At the end of every period the divided comparison pulse `fp` is emitted and both counters reload from the current register inputs.

A separate 14-bit reference counter runs on the oscillator clock and divides it by R to make the reference pulse `fr`. The two paths share only the asynchronous reset. Each path has its own error flag. A flag rises when the programmed values are illegal, and while it is up that path holds its outputs low.

The divide path is a three-state machine:
- `DIV_IDLE` holds the outputs and waits for legal values.
- `DIV_SWALLOW` counts P+1 groups.
- `DIV_MAIN` counts P groups.

Its transitions are:
- LOAD: IDLE→SWALLOW or IDLE→MAIN, chosen by whether A is zero.
- SWALLOW_DONE: SWALLOW→MAIN.
- RELOAD: SWALLOW or MAIN at the end of a period, back to SWALLOW or MAIN.
- FAULT: end of a period with illegal values, to IDLE.

The reference path has two states:
- `REF_IDLE`, with the transitions REF_LOAD (IDLE→RUN) and REF_FAULT (RUN→IDLE).
- `REF_RUN`, with the transition REF_RELOAD (RUN→RUN).

Top module: `psd_synth_divider`

## Requirements
- R1: With legal values, `fp` pulses exactly once every P·N + A input clock cycles.
- R2: `sel_small` = 1 selects the smaller modulus pair (P = 8 with the default band, 64 with the high band). `sel_small` = 0 selects the larger pair (P = 16, or 128 with the high band).
- R3: `mod_ctl` is high for exactly the first A·(P+1) input cycles of every period and low for the rest. It is always low in the cycle before an `fp` pulse.
- R4: When N < 3 or A ≥ N is present at a load point, `div_cfg_err` goes high and `fp` and `mod_ctl` stay low for as long as it remains high. The period that has just ended still gives its `fp` pulse.
- R5: Changes to N, A or `sel_small` in mid-period do not alter the current period. They take effect from the next period boundary.
- R6: With legal R, `fr` pulses once every R oscillator cycles.
- R7: When R < 3 is present at a load point, `ref_cfg_err` goes high and `fr` stays low.
- R8: `fp` and `fr` are each exactly one cycle of their own clock wide.
- R9: While `rst_n` is low, all outputs are low.
- R10: From the error state, the first clock edge that sees legal values clears the flag and starts a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Fast input clock being divided |
| osc_clk | input | 1 | Oscillator clock for the reference counter |
| rst_n | input | 1 | Asynchronous active-low reset for both paths |
| n_val | input | 11 | Main counter value N |
| a_val | input | 7 | Swallow counter value A |
| sel_small | input | 1 | Prescaler pair select (1 = smaller P) |
| r_val | input | 14 | Reference divide value R |
| fp | output | 1 | Divided comparison pulse (in_clk domain) |
| fr | output | 1 | Reference pulse (osc_clk domain) |
| mod_ctl | output | 1 | Modulus control: high while dividing by P+1 |
| div_cfg_err | output | 1 | Divide-path configuration error |
| ref_cfg_err | output | 1 | Reference-path configuration error |

## Verification
The end of a period and the sampling of new register values fall in the same cycle, and this is where the design is most exposed. The bench changes N, A and the select in mid-period, then checks that the running period keeps its old length and the next one takes the new length. It then programs an illegal N just before a boundary and checks that the final `fp` pulse and the rising error flag appear together on the same edge. A behavioural model that counts cycles against the requirements compares every output on every clock of both domains.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [1:0] {
        DIV_IDLE    = 2'd0,
        DIV_SWALLOW = 2'd1,
        DIV_MAIN    = 2'd2
    } div_state_e;

    typedef enum logic {
        REF_IDLE = 1'b0,
        REF_RUN  = 1'b1
    } ref_state_e;

    // Smaller base modulus of the selected band.
    function automatic int base_modulus(input bit high_band);
        return high_band ? 64 : 8;
    endfunction

endpackage

// File: rtl/psd_div_fsm.sv
module psd_div_fsm
    import psd_pkg::*;
#(
    parameter int MAIN_W = 11,
    parameter int SWAL_W = 7,
    parameter int P_LO   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] n_val,
    input  logic [SWAL_W-1:0] a_val,
    input  logic              sel_small,
    output logic              fp,
    output logic              mod_ctl,
    output logic              cfg_err
);

    localparam int P_HI  = 2 * P_LO;
    localparam int PRE_W = $clog2(P_HI + 1);
    localparam logic [PRE_W-1:0]  PRE_ONE  = PRE_W'(1);
    localparam logic [MAIN_W-1:0] MAIN_ONE = MAIN_W'(1);
    localparam logic [SWAL_W-1:0] SWAL_ONE = SWAL_W'(1);

    div_state_e        st_q, st_d;
    logic [PRE_W-1:0]  pre_q, pre_d, p_q, p_d, p_now;
    logic [SWAL_W-1:0] swal_q, swal_d;
    logic [MAIN_W-1:0] main_q, main_d;
    logic              cfg_ok, do_load, terminal;

    assign p_now  = sel_small ? PRE_W'(P_LO) : PRE_W'(P_HI);
    assign cfg_ok = (n_val >= MAIN_W'(3)) && (MAIN_W'(a_val) < n_val);

    // Next-state and counter logic.
    always_comb begin
        st_d     = st_q;
        pre_d    = pre_q;
        swal_d   = swal_q;
        main_d   = main_q;
        p_d      = p_q;
        do_load  = 1'b0;
        terminal = 1'b0;
        unique case (st_q)
            DIV_IDLE: begin
                do_load = cfg_ok;
            end
            DIV_SWALLOW, DIV_MAIN: begin
                if (pre_q != '0) begin
                    pre_d = pre_q - PRE_ONE;
                end else if (main_q == MAIN_ONE) begin
                    terminal = 1'b1;
                    if (cfg_ok) do_load = 1'b1;
                    else        st_d    = DIV_IDLE;
                end else begin
                    main_d = main_q - MAIN_ONE;
                    if (st_q == DIV_SWALLOW && swal_q != SWAL_ONE) begin
                        swal_d = swal_q - SWAL_ONE;
                        pre_d  = p_q;
                    end else begin
                        st_d  = DIV_MAIN;
                        pre_d = p_q - PRE_ONE;
                    end
                end
            end
            default: st_d = DIV_IDLE;
        endcase
        if (do_load) begin
            st_d   = (a_val != '0) ? DIV_SWALLOW : DIV_MAIN;
            pre_d  = (a_val != '0) ? p_now : (p_now - PRE_ONE);
            swal_d = a_val;
            main_d = n_val;
            p_d    = p_now;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DIV_IDLE;
            pre_q  <= '0;
            swal_q <= '0;
            main_q <= '0;
            p_q    <= '0;
        end else begin
            st_q   <= st_d;
            pre_q  <= pre_d;
            swal_q <= swal_d;
            main_q <= main_d;
            p_q    <= p_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fp      <= 1'b0;
            mod_ctl <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            fp      <= terminal;
            mod_ctl <= (st_d == DIV_SWALLOW);
            cfg_err <= (st_d == DIV_IDLE);
        end
    end

endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div
    import psd_pkg::*;
#(
    parameter int REF_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] r_val,
    output logic             fr,
    output logic             cfg_err
);

    localparam logic [REF_W-1:0] REF_ONE = REF_W'(1);

    ref_state_e       st_q, st_d;
    logic [REF_W-1:0] cnt_q, cnt_d;
    logic             cfg_ok, do_load, terminal;

    assign cfg_ok = (r_val >= REF_W'(3));

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        do_load  = 1'b0;
        terminal = 1'b0;
        unique case (st_q)
            REF_IDLE: do_load = cfg_ok;
            REF_RUN: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - REF_ONE;
                end else begin
                    terminal = 1'b1;
                    if (cfg_ok) do_load = 1'b1;
                    else        st_d    = REF_IDLE;
                end
            end
            default: st_d = REF_IDLE;
        endcase
        if (do_load) begin
            st_d  = REF_RUN;
            cnt_d = r_val - REF_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= REF_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr      <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            fr      <= terminal;
            cfg_err <= (st_d == REF_IDLE);
        end
    end

endmodule

// File: rtl/psd_synth_divider.sv
module psd_synth_divider
    import psd_pkg::*;
#(
    parameter bit HIGH_BAND = 1'b0,
    parameter int MAIN_W    = 11,
    parameter int SWAL_W    = 7,
    parameter int REF_W     = 14
) (
    input  logic              in_clk,
    input  logic              osc_clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] n_val,
    input  logic [SWAL_W-1:0] a_val,
    input  logic              sel_small,
    input  logic [REF_W-1:0]  r_val,
    output logic              fp,
    output logic              fr,
    output logic              mod_ctl,
    output logic              div_cfg_err,
    output logic              ref_cfg_err
);

    localparam int P_LO = base_modulus(HIGH_BAND);

    psd_div_fsm #(
        .MAIN_W(MAIN_W),
        .SWAL_W(SWAL_W),
        .P_LO  (P_LO)
    ) u_div (
        .clk      (in_clk),
        .rst_n    (rst_n),
        .n_val    (n_val),
        .a_val    (a_val),
        .sel_small(sel_small),
        .fp       (fp),
        .mod_ctl  (mod_ctl),
        .cfg_err  (div_cfg_err)
    );

    psd_ref_div #(
        .REF_W(REF_W)
    ) u_ref (
        .clk    (osc_clk),
        .rst_n  (rst_n),
        .r_val  (r_val),
        .fr     (fr),
        .cfg_err(ref_cfg_err)
    );

endmodule

// File: rtl/psd_synth_checker.sv
module psd_synth_checker (
    input logic in_clk,
    input logic osc_clk,
    input logic rst_n,
    input logic fp,
    input logic fr,
    input logic mod_ctl,
    input logic div_cfg_err,
    input logic ref_cfg_err
);

    // R8
    fp_single_pulse_chk: assert property (@(posedge in_clk) disable iff (!rst_n)
        fp |=> !fp);

    // R8
    fr_single_pulse_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        fr |=> !fr);

    // R4
    div_hold_chk: assert property (@(posedge in_clk) disable iff (!rst_n)
        (div_cfg_err && $past(div_cfg_err)) |-> (!fp && !mod_ctl));

    // R4
    err_excl_chk: assert property (@(posedge in_clk) disable iff (!rst_n)
        div_cfg_err |-> !mod_ctl);

    // R7
    ref_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (ref_cfg_err && $past(ref_cfg_err)) |-> !fr);

    // R3
    swallow_before_end_chk: assert property (@(posedge in_clk) disable iff (!rst_n)
        fp |-> !$past(mod_ctl));

endmodule

bind psd_synth_divider psd_synth_checker u_chk (.*);

// File: tb/psd_synth_divider_tb.sv
module psd_synth_divider_tb;

    logic        in_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] n_val = 11'd5;
    logic [6:0]  a_val = 7'd2;
    logic        sel_small = 1'b1;
    logic [13:0] r_val = 14'd10;
    logic        fp, fr, mod_ctl, div_cfg_err, ref_cfg_err;

    int checks = 0;
    int fails  = 0;

    always #4  in_clk  = ~in_clk;
    always #11 osc_clk = ~osc_clk;

    psd_synth_divider u_dut (
        .in_clk(in_clk), .osc_clk(osc_clk), .rst_n(rst_n),
        .n_val(n_val), .a_val(a_val), .sel_small(sel_small), .r_val(r_val),
        .fp(fp), .fr(fr), .mod_ctl(mod_ctl),
        .div_cfg_err(div_cfg_err), .ref_cfg_err(ref_cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, divide path.
    int  d_pos, d_per, d_span;
    bit  d_run, e_fp, e_mod, e_err;
    always @(posedge in_clk or negedge rst_n) begin
        if (!rst_n) begin
            d_run = 0; d_pos = 0; d_per = 0; d_span = 0;
            e_fp = 0; e_mod = 0; e_err = 0;
        end else begin
            e_fp = 0;
            if (d_run) begin
                d_pos++;
                if (d_pos == d_per) begin
                    e_fp = 1;
                    d_run = 0;
                end
            end
            if (!d_run && int'(n_val) >= 3 && int'(a_val) < int'(n_val)) begin
                int p;
                p = sel_small ? 8 : 16;
                d_run = 1;
                d_pos = 0;
                d_per = p * int'(n_val) + int'(a_val);
                d_span = int'(a_val) * (p + 1);
            end
            e_err = !d_run;
            e_mod = d_run && (d_pos < d_span);
        end
    end

    // Behavioural reference model, reference path.
    int r_pos, r_per;
    bit r_run, e_fr, e_rerr;
    always @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            r_run = 0; r_pos = 0; r_per = 0; e_fr = 0; e_rerr = 0;
        end else begin
            e_fr = 0;
            if (r_run) begin
                r_pos++;
                if (r_pos == r_per) begin
                    e_fr = 1;
                    r_run = 0;
                end
            end
            if (!r_run && int'(r_val) >= 3) begin
                r_run = 1;
                r_pos = 0;
                r_per = int'(r_val);
            end
            e_rerr = !r_run;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge in_clk) begin
        if (rst_n) begin
            chk(fp == e_fp, "R1 fp vs model", fp, e_fp);
            chk(mod_ctl == e_mod, "R3 mod_ctl vs model", mod_ctl, e_mod);
            chk(div_cfg_err == e_err, "R4 div_cfg_err vs model", div_cfg_err, e_err);
        end
    end
    always @(negedge osc_clk) begin
        if (rst_n) begin
            chk(fr == e_fr, "R6 fr vs model", fr, e_fr);
            chk(ref_cfg_err == e_rerr, "R7 ref_cfg_err vs model", ref_cfg_err, e_rerr);
        end
    end

    task automatic wait_fp();
        int guard = 0;
        do begin
            @(negedge in_clk);
            guard++;
        end while (!fp && guard < 50000);
    endtask

    // Counts samples from one fp pulse to the next, and mod_ctl-high samples.
    task automatic measure_fp(output int per, output int modc);
        wait_fp();
        per = 0;
        modc = mod_ctl ? 1 : 0;
        @(negedge in_clk);
        per = 1;
        chk(fp == 1'b0, "R8 fp one cycle wide", fp, 0);
        while (!fp && per < 50000) begin
            if (mod_ctl) modc++;
            @(negedge in_clk);
            per++;
        end
    endtask

    task automatic measure_fr(output int per);
        int guard = 0;
        do begin
            @(negedge osc_clk);
            guard++;
        end while (!fr && guard < 50000);
        @(negedge osc_clk);
        per = 1;
        chk(fr == 1'b0, "R8 fr one cycle wide", fr, 0);
        while (!fr && per < 50000) begin
            @(negedge osc_clk);
            per++;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int per, modc, cnt;
        // R9: reset state
        repeat (3) begin
            @(negedge in_clk);
            chk(fp == 0, "R9 fp in reset", fp, 0);
            chk(mod_ctl == 0, "R9 mod_ctl in reset", mod_ctl, 0);
            chk(div_cfg_err == 0, "R9 div_cfg_err in reset", div_cfg_err, 0);
            chk(fr == 0, "R9 fr in reset", fr, 0);
            chk(ref_cfg_err == 0, "R9 ref_cfg_err in reset", ref_cfg_err, 0);
        end
        rst_n = 1'b1;

        // R1: P=8, N=5, A=2
        measure_fp(per, modc);
        chk(per == 42, "R1 period 8*5+2", per, 42);
        chk(modc == 18, "R3 swallow span 2*9", modc, 18);

        // R5: change select mid-period, current period keeps old length
        wait_fp();
        repeat (10) @(negedge in_clk);
        sel_small = 1'b0;
        cnt = 10;
        do begin
            @(negedge in_clk);
            cnt++;
        end while (!fp && cnt < 50000);
        chk(cnt == 42, "R5 running period unchanged", cnt, 42);

        // R2: larger pair, P=16
        measure_fp(per, modc);
        chk(per == 82, "R2 period 16*5+2", per, 82);

        // R1: minimum N, no swallow
        n_val = 11'd3; a_val = 7'd0; sel_small = 1'b1;
        wait_fp();
        measure_fp(per, modc);
        chk(per == 24, "R1 period 8*3+0", per, 24);
        chk(modc == 0, "R3 no swallow when A=0", modc, 0);

        // R3: long swallow span
        n_val = 11'd10; a_val = 7'd9; sel_small = 1'b0;
        wait_fp();
        measure_fp(per, modc);
        chk(per == 169, "R1 period 16*10+9", per, 169);
        chk(modc == 153, "R3 swallow span 9*17", modc, 153);

        // R4: N below 3; last pulse and error on the same edge
        n_val = 11'd2;
        wait_fp();
        chk(div_cfg_err == 1, "R4 error with final pulse", div_cfg_err, 1);
        cnt = 0;
        repeat (100) begin
            @(negedge in_clk);
            if (fp) cnt++;
        end
        chk(cnt == 0, "R4 fp held low", cnt, 0);

        // R4: A equal to N
        n_val = 11'd3; a_val = 7'd3;
        repeat (5) @(negedge in_clk);
        chk(div_cfg_err == 1, "R4 error for A>=N", div_cfg_err, 1);

        // R10: recovery
        n_val = 11'd4; a_val = 7'd3; sel_small = 1'b1;
        @(negedge in_clk);
        chk(div_cfg_err == 0, "R10 error cleared", div_cfg_err, 0);
        chk(mod_ctl == 1, "R10 fresh period swallowing", mod_ctl, 1);
        measure_fp(per, modc);
        chk(per == 35, "R10 period 8*4+3", per, 35);

        // R6: reference divider
        measure_fr(per);
        chk(per == 10, "R6 fr period 10", per, 10);

        // R7: R below 3
        @(negedge osc_clk);
        r_val = 14'd2;
        repeat (30) @(negedge osc_clk);
        chk(ref_cfg_err == 1, "R7 ref error", ref_cfg_err, 1);
        cnt = 0;
        repeat (20) begin
            @(negedge osc_clk);
            if (fr) cnt++;
        end
        chk(cnt == 0, "R7 fr held low", cnt, 0);

        // R10 and R6: recovery at minimum R
        r_val = 14'd3;
        @(negedge osc_clk);
        chk(ref_cfg_err == 0, "R10 ref error cleared", ref_cfg_err, 0);
        measure_fr(per);
        chk(per == 3, "R6 fr period 3", per, 3);

        @(negedge osc_clk);
        r_val = 14'd300;
        measure_fr(per);
        measure_fr(per);
        chk(per == 300, "R6 fr period 300", per, 300);

        finish_run();
    end

endmodule